// File: doc/BRIEF.md
# Prescaled Oversampling Tick Generator

This block turns a fast reference clock into a stream of one-cycle clock-enable pulses. A serial receiver or transmitter samples each bit period sixteen times, and it uses these pulses as its sampling strobe. The pulse rate is set by one configuration word. That word holds an enable flag, a divide count stored as the count minus one, and a select flag. The select flag places an extra fixed divide-by-sixteen stage in front of the main divider, so a single 13-bit setting covers both fast and slow line rates.

Software writes the word through a plain register port with one write strobe and a read-back bus. Each write restarts both counting stages from zero, so the phase of the tick train after a write is known exactly. The generator never computes a divisor from a requested line rate. Whoever programs the register picks the field value.

Top module: `osc_tick_gen`

## Requirements
- R1: After reset the read-back bus is 0 and no ticks are produced until a write enables the generator.
- R2: Reading returns the last written bits 16:0 unchanged, and bits 31:17 always read 0 whatever was written there.
- R3: While bit 16 (enable) of the register is 0, `tick` stays low on every cycle.
- R4: With bit 0 clear, the tick period is (bits 12:1 + 1) reference cycles.
- R5: With bit 0 set, the tick period is (bits 12:1 + 1) × 16 reference cycles.
- R6: A write restarts both stages. When the generator is enabled with period P, the first tick falls in the P-th cycle after the write edge, and a rewrite part-way through a period moves the next tick to P cycles after the rewrite.
- R7: When the period is greater than 1, each tick is high for exactly one reference cycle.
- R8: With bits 12:1 equal to 0 and bit 0 clear, `tick` is high on every enabled cycle.
- R9: The largest setting (bits 12:1 = 4095, bit 0 = 1) gives its first tick exactly 65536 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Read-back of the configuration word |
| tick | output | 1 | One-cycle oversampling enable pulse |

## Verification
The hardest case to reach is the slowest setting, where the prescale stage and the main counter both wrap at their last values in the same cycle, 65536 cycles after a write. The bench programs that setting directly and counts cycles up to that tick. The second hard case is a rewrite in the middle of a period, which has to throw away a partly elapsed count. The bench rewrites the same value a few cycles into a period and checks that the next tick moves to a full period after the rewrite. A behavioural model that keeps one flat cycle counter is compared with `tick` on every cycle.

// File: rtl/osc_tick_pkg.sv
package osc_tick_pkg;

  localparam int unsigned DEF_BUS_W    = 32;
  localparam int unsigned DEF_DIV_W    = 12;
  localparam int unsigned DEF_PRE_LOG2 = 4;
  localparam int unsigned DEF_EN_BIT   = 16;

  // Reference cycles between ticks for one setting.
  function automatic int unsigned otg_period(int unsigned div_m1,
                                             logic pre_sel,
                                             int unsigned pre_log2);
    int unsigned base;
    base = div_m1 + 1;
    return pre_sel ? (base << pre_log2) : base;
  endfunction

endpackage

// File: rtl/osc_tick_cfg.sv
module osc_tick_cfg #(
  parameter int unsigned BUS_W  = osc_tick_pkg::DEF_BUS_W,
  parameter int unsigned DIV_W  = osc_tick_pkg::DEF_DIV_W,
  parameter int unsigned EN_BIT = osc_tick_pkg::DEF_EN_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  output logic             gen_en,
  output logic [DIV_W-1:0] div_m1,
  output logic             pre_sel,
  output logic             restart
);

  localparam int unsigned KEEP_W = EN_BIT + 1;
  localparam int unsigned ZERO_W = BUS_W - KEEP_W;

  logic [KEEP_W-1:0] cfg_q;
  logic              unused_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= wr_data[KEEP_W-1:0];
    end
  end

  assign unused_hi = ^wr_data[BUS_W-1:KEEP_W];
  assign rd_data   = {{ZERO_W{1'b0}}, cfg_q};
  assign gen_en    = cfg_q[EN_BIT];
  assign div_m1    = cfg_q[DIV_W:1];
  assign pre_sel   = cfg_q[0];
  assign restart   = wr_en;

  // R2: read-back mirrors the kept bits of the previous write, upper bits zero
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {{ZERO_W{1'b0}}, $past(wr_data[KEEP_W-1:0])});

endmodule

// File: rtl/osc_tick_prescale.sv
module osc_tick_prescale #(
  parameter int unsigned PRE_LOG2 = osc_tick_pkg::DEF_PRE_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_en,
  input  logic restart,
  input  logic pre_sel,
  output logic stage_pulse
);

  generate
    if (PRE_LOG2 == 0) begin : g_bypass
      assign stage_pulse = gen_en;
    end else begin : g_count
      localparam logic [PRE_LOG2-1:0] PRE_LAST = '1;
      logic [PRE_LOG2-1:0] pre_cnt_q;
      logic                pre_wrap;

      assign pre_wrap = (pre_cnt_q == PRE_LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || restart || !gen_en || !pre_sel) begin
          pre_cnt_q <= '0;
        end else begin
          pre_cnt_q <= pre_cnt_q + 1'b1;
        end
      end

      assign stage_pulse = gen_en && (!pre_sel || pre_wrap);

      // R5: with prescale on, two stage pulses are never back to back
      assert_pre_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_pulse && pre_sel && !restart) |=> !stage_pulse);
    end
  endgenerate

endmodule

// File: rtl/osc_tick_main_div.sv
module osc_tick_main_div #(
  parameter int unsigned DIV_W = osc_tick_pkg::DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             restart,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !gen_en) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = step && at_limit;

  // R4: the main count never runs past the programmed limit
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

endmodule

// File: rtl/osc_tick_gen.sv
module osc_tick_gen #(
  parameter int unsigned BUS_W    = osc_tick_pkg::DEF_BUS_W,
  parameter int unsigned DIV_W    = osc_tick_pkg::DEF_DIV_W,
  parameter int unsigned PRE_LOG2 = osc_tick_pkg::DEF_PRE_LOG2,
  parameter int unsigned EN_BIT   = osc_tick_pkg::DEF_EN_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [BUS_W-1:0] cfg_wr_data,
  output logic [BUS_W-1:0] cfg_rd_data,
  output logic             tick
);

  logic             gen_en;
  logic [DIV_W-1:0] div_m1;
  logic             pre_sel;
  logic             restart;
  logic             stage_pulse;
  int unsigned      cur_period;
  int unsigned      new_period;

  osc_tick_cfg #(.BUS_W(BUS_W), .DIV_W(DIV_W), .EN_BIT(EN_BIT)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .gen_en(gen_en), .div_m1(div_m1),
    .pre_sel(pre_sel), .restart(restart)
  );

  osc_tick_prescale #(.PRE_LOG2(PRE_LOG2)) pre_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .restart(restart),
    .pre_sel(pre_sel), .stage_pulse(stage_pulse)
  );

  osc_tick_main_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .restart(restart),
    .step(stage_pulse), .limit(div_m1), .tick(tick)
  );

  assign cur_period = osc_tick_pkg::otg_period(32'(div_m1), pre_sel, PRE_LOG2);
  assign new_period = osc_tick_pkg::otg_period(32'(cfg_wr_data[DIV_W:1]),
                                               cfg_wr_data[0], PRE_LOG2);

  // R3: a disabled generator never ticks
  assert_no_tick_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> !tick);

  // R8: the fastest setting ticks on every enabled cycle
  assert_every_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && div_m1 == '0 && !pre_sel) |-> tick);

  // R7: ticks are one cycle wide when the period exceeds one
  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_wr_en && cur_period > 1) |=> !tick);

  // R6: a write with a period above one gives no tick in the next cycle
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && new_period > 1) |=> !tick);

endmodule

// File: tb/osc_tick_gen_tb_top.sv
module osc_tick_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        tick;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // model state
  logic [16:0] m_cfg = '0;
  int          m_cnt = 0;

  always #4 clk = ~clk;

  osc_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .tick(tick)
  );

  function automatic int m_period(logic [16:0] c);
    int mult;
    mult = c[0] ? 16 : 1;
    return (int'(c[12:1]) + 1) * mult;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = '0;
      m_cnt = 0;
    end else if (cfg_wr_en) begin
      m_cfg = cfg_wr_data[16:0];
      m_cnt = 0;
    end else if (m_cfg[16]) begin
      m_cnt = (m_cnt == m_period(m_cfg) - 1) ? 0 : m_cnt + 1;
    end else begin
      m_cnt = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_t;
      #1;
      exp_t = m_cfg[16] && (m_cnt == m_period(m_cfg) - 1);
      check(cur_req, 32'(tick), 32'(exp_t), "per-cycle tick");
    end
  end

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = d;
    @(posedge clk);
    #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic count_ticks(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
      if (tick) c++;
    end
  endtask

  function automatic logic [31:0] cfgw(bit en, int n_m1, bit pre);
    return {15'b0, en, 3'b0, 12'(n_m1), pre};
  endfunction

  initial begin
    int c;
    repeat (3) @(negedge clk);
    #2;
    check("R1", cfg_rd_data, 32'h0, "read-back in reset");
    rst_n = 1'b1;
    count_ticks(20, c);
    check("R1", 32'(c), 0, "ticks after reset");

    cur_req = "R2";
    wr(32'hFFFE_A5A4);
    #1;
    check("R2", cfg_rd_data, 32'h0000_A5A4, "upper bits dropped");

    cur_req = "R3";
    wr(cfgw(0, 0, 0));
    count_ticks(50, c);
    check("R3", 32'(c), 0, "disabled, fastest field");
    wr(cfgw(0, 3, 1));
    count_ticks(100, c);
    check("R3", 32'(c), 0, "disabled, prescaled field");

    cur_req = "R4";
    wr(cfgw(1, 4, 0));
    count_ticks(20, c);
    check("R4", 32'(c), 4, "period 5 over 20 cycles");
    wr(cfgw(1, 6, 0));
    count_ticks(70, c);
    check("R4", 32'(c), 10, "period 7 over 70 cycles");

    cur_req = "R5";
    wr(cfgw(1, 2, 1));
    count_ticks(96, c);
    check("R5", 32'(c), 2, "period 48 over 96 cycles");
    wr(cfgw(1, 0, 1));
    count_ticks(64, c);
    check("R5", 32'(c), 4, "period 16 over 64 cycles");

    cur_req = "R6";
    wr(cfgw(1, 9, 0));
    count_ticks(9, c);
    check("R6", 32'(c), 0, "no tick before 10th cycle");
    count_ticks(1, c);
    check("R6", 32'(c), 1, "tick in 10th cycle");
    count_ticks(7, c);
    wr(cfgw(1, 9, 0));
    count_ticks(9, c);
    check("R6", 32'(c), 0, "rewrite mid-period delays tick");
    count_ticks(1, c);
    check("R6", 32'(c), 1, "tick 10 cycles after rewrite");

    cur_req = "R7";
    wr(cfgw(1, 1, 0));
    count_ticks(40, c);
    check("R7", 32'(c), 20, "period 2 single-cycle ticks");

    cur_req = "R8";
    wr(cfgw(1, 0, 0));
    count_ticks(25, c);
    check("R8", 32'(c), 25, "tick every cycle");

    cur_req = "R4";
    wr(cfgw(1, 4095, 0));
    count_ticks(8192, c);
    check("R4", 32'(c), 2, "largest unprescaled period");

    cur_req = "R9";
    wr(cfgw(1, 4095, 1));
    count_ticks(65535, c);
    check("R9", 32'(c), 0, "no tick before 65536th cycle");
    count_ticks(1, c);
    check("R9", 32'(c), 1, "tick in 65536th cycle");
    count_ticks(3, c);
    check("R9", 32'(c), 0, "quiet after slow tick");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1'b1;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule